// File: doc/BRIEF.md
# Multi-channel DMA interrupt aggregator

This block gathers completion events from a set of DMA channels into interrupt enable and pending registers and drives one combined interrupt line. Each channel raises three kinds of single-cycle event pulses: one when half of a transfer is done, one when a package is done, and one when its whole queue is done. An event is recorded in a pending bit only if software has enabled that event for that channel. The interrupt line stays high while any pending bit is set.

Software reaches the state through a 32-bit register port with a write strobe and a combinational read path. Every channel owns a 4-bit field. Eight such fields fill one 32-bit word, so 16 channels need two enable words and two pending words. To acknowledge interrupts, software writes back the pending value it read. A 1 clears the bit in that position and a 0 leaves it unchanged. A status word reports which channels are busy, taken from a busy input vector. The event sources and the channel arbitration are outside this block.

Top module: `irq_event_aggregator`

## Requirements
- R1: Channel n uses word n/8 of each bank, with its field starting at bit (n mod 8)*4. Inside the field, bit 0 is half-done, bit 1 is package-done and bit 2 is queue-done.
- R2: The enable words sit at 0x00 (channels 0-7) and 0x04 (channels 8-15). A write stores the field bits, and a read returns them with bit 3 of every field as 0.
- R3: A pending bit is set after a clock edge at which its event input is high and its enable bit was already set before that edge. Events on disabled bits leave the pending words unchanged.
- R4: The pending words sit at 0x10 and 0x14. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and bit 3 of every field reads 0.
- R5: When an enabled event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R6: irq_o is high exactly while at least one pending bit is set. It follows the pending words without extra delay.
- R7: After 0 is written to both enable words, no event sets any pending bit and irq_o stays low.
- R8: The word at 0x30 returns busy_i in bits 15:0 and 0 in bits 31:16. Writes to 0x30 have no effect.
- R9: Any other address reads 0, and writes to it change no enable or pending bit.
- R10: After reset, all enable and pending bits are 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte address of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_half_i | input | 16 | Half-done event pulse, one bit per channel |
| evt_pkg_i | input | 16 | Package-done event pulse, one bit per channel |
| evt_queue_i | input | 16 | Queue-done event pulse, one bit per channel |
| busy_i | input | 16 | Channel busy flags, one bit per channel |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Two functions can act on the same pending bit in one cycle: a new enabled event and the write-one acknowledge from software. The bench first sets two pending bits. It then writes 1s to both of them while pulsing the event for only one of them. The result must be that the re-triggered bit survives, the other bit is gone, and irq_o stays high. A second case pulses events on disabled bits during the clearing write; this must neither block the clear nor set anything.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int FIELD_W = 4;   // bits reserved per channel in a word
  localparam int EV_N    = 3;   // event kinds per channel
  localparam int EV_HALF  = 0;
  localparam int EV_PKG   = 1;
  localparam int EV_QUEUE = 2;

  // word index that holds a channel
  function automatic int word_of(input int ch, input int per_word);
    return ch / per_word;
  endfunction

  // lowest bit of a channel's field within its word
  function automatic int field_lsb(input int ch, input int per_word);
    return (ch % per_word) * FIELD_W;
  endfunction

  // flat index of (channel, event) inside the per-channel vectors
  function automatic int flat_idx(input int ch, input int ev);
    return ch * EV_N + ev;
  endfunction
endpackage

// File: rtl/irq_evt_cell.sv
module irq_evt_cell
  import irq_aggr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_we_i,
  input  logic [EV_N-1:0] en_d_i,
  input  logic [EV_N-1:0] clr_i,
  input  logic [EV_N-1:0] ev_i,
  output logic [EV_N-1:0] en_q_o,
  output logic [EV_N-1:0] pend_q_o
);
  logic [EV_N-1:0] latch_now;

  // an event counts only against the enable held before this edge
  assign latch_now = ev_i & en_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o   <= '0;
      pend_q_o <= '0;
    end else begin
      if (en_we_i) en_q_o <= en_d_i;
      // set has priority over write-one clear
      pend_q_o <= (pend_q_o & ~clr_i) | latch_now;
    end
  end
endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int ADDR_W    = 8,
  parameter int NWORD     = 2,
  parameter int EN_BASE   = 'h00,
  parameter int PEND_BASE = 'h10,
  parameter int STAT_ADDR = 'h30
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NWORD-1:0]  en_hit_o,
  output logic [NWORD-1:0]  pend_hit_o,
  output logic              stat_hit_o
);
  always_comb begin
    for (int w = 0; w < NWORD; w++) begin
      en_hit_o[w]   = (addr_i == ADDR_W'(EN_BASE + 4 * w));
      pend_hit_o[w] = (addr_i == ADDR_W'(PEND_BASE + 4 * w));
    end
    stat_hit_o = (addr_i == ADDR_W'(STAT_ADDR));
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_aggr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  parameter int NWORD  = 2
) (
  input  logic [NUM_CH*EV_N-1:0] en_vec_i,
  input  logic [NUM_CH*EV_N-1:0] pend_vec_i,
  input  logic [NUM_CH-1:0]      busy_i,
  input  logic [NWORD-1:0]       en_hit_i,
  input  logic [NWORD-1:0]       pend_hit_i,
  input  logic                   stat_hit_i,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int PER_WORD = DATA_W / FIELD_W;

  // place the channel fields of one word; spare field bits stay 0
  function automatic logic [DATA_W-1:0] pack_word(
      input logic [NUM_CH*EV_N-1:0] vec, input int w);
    logic [DATA_W-1:0] word;
    word = '0;
    for (int c = 0; c < PER_WORD; c++) begin
      if (w * PER_WORD + c < NUM_CH)
        word[c*FIELD_W +: EV_N] = vec[flat_idx(w * PER_WORD + c, 0) +: EV_N];
    end
    return word;
  endfunction

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (en_hit_i[w])   rdata_o = pack_word(en_vec_i, w);
      if (pend_hit_i[w]) rdata_o = pack_word(pend_vec_i, w);
    end
    if (stat_hit_i) rdata_o[NUM_CH-1:0] = busy_i;
  end
endmodule

// File: rtl/irq_event_aggregator.sv
module irq_event_aggregator
  import irq_aggr_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int EN_BASE   = 'h00,
  parameter int PEND_BASE = 'h10,
  parameter int STAT_ADDR = 'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] evt_half_i,
  input  logic [NUM_CH-1:0] evt_pkg_i,
  input  logic [NUM_CH-1:0] evt_queue_i,
  input  logic [NUM_CH-1:0] busy_i,
  output logic              irq_o
);
  localparam int PER_WORD = DATA_W / FIELD_W;
  localparam int NWORD    = (NUM_CH + PER_WORD - 1) / PER_WORD;
  localparam int VEC_W    = NUM_CH * EV_N;

  // named internal events, observed by the bound checker
  logic [VEC_W-1:0] ev_vec;
  logic [VEC_W-1:0] en_vec;
  logic [VEC_W-1:0] pend_vec;
  logic [VEC_W-1:0] clr_vec;
  logic [NWORD-1:0] en_hit;
  logic [NWORD-1:0] pend_hit;
  logic             stat_hit;

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .NWORD(NWORD), .EN_BASE(EN_BASE),
    .PEND_BASE(PEND_BASE), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .addr_i    (addr_i),
    .en_hit_o  (en_hit),
    .pend_hit_o(pend_hit),
    .stat_hit_o(stat_hit)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int W   = word_of(ch, PER_WORD);
    localparam int LSB = field_lsb(ch, PER_WORD);
    localparam int IDX = flat_idx(ch, 0);

    assign ev_vec[IDX + EV_HALF]  = evt_half_i[ch];
    assign ev_vec[IDX + EV_PKG]   = evt_pkg_i[ch];
    assign ev_vec[IDX + EV_QUEUE] = evt_queue_i[ch];
    assign clr_vec[IDX +: EV_N]   = (wr_en_i && pend_hit[W]) ? wdata_i[LSB +: EV_N] : '0;

    irq_evt_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_we_i (wr_en_i && en_hit[W]),
      .en_d_i  (wdata_i[LSB +: EV_N]),
      .clr_i   (clr_vec[IDX +: EV_N]),
      .ev_i    (ev_vec[IDX +: EV_N]),
      .en_q_o  (en_vec[IDX +: EV_N]),
      .pend_q_o(pend_vec[IDX +: EV_N])
    );
  end

  irq_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .NWORD(NWORD)) u_rd (
    .en_vec_i  (en_vec),
    .pend_vec_i(pend_vec),
    .busy_i    (busy_i),
    .en_hit_i  (en_hit),
    .pend_hit_i(pend_hit),
    .stat_hit_i(stat_hit),
    .rdata_o   (rdata_o)
  );

  assign irq_o = |pend_vec;
endmodule

// File: rtl/irq_event_aggregator_chk.sv
module irq_event_aggregator_chk #(
  parameter int VEC_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic [VEC_W-1:0] ev_vec,
  input logic [VEC_W-1:0] en_vec,
  input logic [VEC_W-1:0] pend_vec,
  input logic [VEC_W-1:0] clr_vec
);
  // R3: a bit newly set must have had an enabled event at the previous edge
  p_no_stray_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(ev_vec & en_vec)) == '0));

  // R5: an enabled event always leaves its bit set, whatever the clear
  p_event_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ev_vec & en_vec) & ~pend_vec) == '0));

  // R4: a clear without a competing event leaves the bit low
  p_clear_takes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_vec & $past(clr_vec & ~(ev_vec & en_vec))) == '0));

  // R4: a bit that is not cleared stays set
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_vec & ~clr_vec) & ~pend_vec) == '0));

  // R6: the line rises only after an enabled event
  p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((ev_vec & en_vec) != '0));

  // R6: the line falls only after a clearing write
  p_irq_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_vec != '0));
endmodule

bind irq_event_aggregator irq_event_aggregator_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .ev_vec  (ev_vec),
  .en_vec  (en_vec),
  .pend_vec(pend_vec),
  .clr_vec (clr_vec)
);

// File: tb/irq_event_aggregator_test.sv
`timescale 1ns/1ps
module irq_event_aggregator_test;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] ev_h = '0, ev_p = '0, ev_q = '0, busy = '0;
  logic        irq;
  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  irq_event_aggregator uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_half_i(ev_h), .evt_pkg_i(ev_p),
    .evt_queue_i(ev_q), .busy_i(busy), .irq_o(irq)
  );

  // bit position of (channel, event) in its word: four bits per channel
  function automatic logic [31:0] bit_of(input int ch, input int ev);
    return 32'(1) << ((ch % 8) * 4 + ev);
  endfunction

  function automatic logic [31:0] field_mask(input logic [31:0] v);
    return v & 32'h7777_7777;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus, ending at the following falling edge
  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [NCH-1:0] h, input logic [NCH-1:0] p,
                     input logic [NCH-1:0] q);
    wr_en = w; addr = a; wdata = d; ev_h = h; ev_p = p; ev_q = q;
    @(negedge clk);
    wr_en = 1'b0; ev_h = '0; ev_p = '0; ev_q = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0, '0, '0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int ch, input int ev);
    logic [NCH-1:0] one;
    one = NCH'(1) << ch;
    cyc(1'b0, 8'h00, '0, (ev == 0) ? one : '0, (ev == 1) ? one : '0,
        (ev == 2) ? one : '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] e0, e1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 irq", {31'b0, irq}, 0);
    foreach (e0[i]) begin end
    for (int a = 0; a < 'h40; a += 4) begin
      if (a != 'h30) begin rd(8'(a), v); check("R10 regs", v, 0); end
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: enable read-back with spare field bits forced to 0
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 en0", v, 32'h7777_7777);
    wr(8'h04, 32'h1234_5678); rd(8'h04, v); check("R2 en1", v, field_mask(32'h1234_5678));
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00, v); check("R2 en0b", v, field_mask(32'hA5A5_0F0F));

    // R1/R3/R4/R6: sweep every (channel, event) with a single enable bit
    for (int ch = 0; ch < NCH; ch++) begin
      for (int ev = 0; ev < 3; ev++) begin
        e0 = (ch < 8) ? bit_of(ch, ev) : 32'h0;
        e1 = (ch < 8) ? 32'h0 : bit_of(ch, ev);
        wr(8'h00, e0); wr(8'h04, e1);
        // R3: all other events while only this bit is enabled
        cyc(1'b0, 8'h00, '0, ~('0), ~('0), ~('0) );
        // the all-ones pulse includes the enabled one; clear it to restart
        rd(8'h10, v); check("R1 pend0 all", v, e0);
        rd(8'h14, v); check("R1 pend1 all", v, e1);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
        check("R6 low after clear", {31'b0, irq}, 0);
        // disabled events on the same channel only
        for (int o = 0; o < 3; o++) if (o != ev) pulse(ch, o);
        rd(8'h10 + 8'(4 * (ch / 8)), v); check("R3 disabled ignored", v, 0);
        pulse(ch, ev);
        rd(8'h10, v); check("R1 pend0", v, e0);
        rd(8'h14, v); check("R1 pend1", v, e1);
        check("R6 irq high", {31'b0, irq}, 1);
        // R4: writing zeros leaves it, writing its one clears it
        wr(8'h10 + 8'(4 * (ch / 8)), 32'h0);
        rd(8'h10 + 8'(4 * (ch / 8)), v); check("R4 zero write", v, e0 | e1);
        wr(8'h10 + 8'(4 * (ch / 8)), e0 | e1);
        rd(8'h10 + 8'(4 * (ch / 8)), v); check("R4 one clears", v, 0);
        check("R6 irq low", {31'b0, irq}, 0);
      end
    end

    // R5: event and clear on the same bit in one cycle
    wr(8'h00, 32'h7777_7777); wr(8'h04, 32'h7777_7777);
    cyc(1'b0, 8'h00, '0, 16'h0009, '0, '0);          // ch0 and ch3 half
    rd(8'h10, v); check("R5 setup", v, bit_of(0, 0) | bit_of(3, 0));
    cyc(1'b1, 8'h10, bit_of(0, 0) | bit_of(3, 0), 16'h0008, '0, '0);
    rd(8'h10, v); check("R5 event wins", v, bit_of(3, 0));
    check("R5 irq kept", {31'b0, irq}, 1);
    wr(8'h10, bit_of(3, 0));
    rd(8'h10, v); check("R5 final clear", v, 0);

    // R7: both enables zero masks every event
    wr(8'h00, 32'h0); wr(8'h04, 32'h0);
    cyc(1'b0, 8'h00, '0, '1, '1, '1);
    rd(8'h10, v); check("R7 pend0", v, 0);
    rd(8'h14, v); check("R7 pend1", v, 0);
    check("R7 irq", {31'b0, irq}, 0);
    // disabled events during a clearing write change nothing either
    cyc(1'b1, 8'h14, 32'hFFFF_FFFF, '1, '1, '1);
    rd(8'h14, v); check("R7 with clear", v, 0);

    // R8: busy flags
    for (int i = 0; i < NCH; i++) begin
      busy = NCH'(1) << i;
      rd(8'h30, v); check("R8 busy walk", v, 32'(1) << i);
    end
    busy = 16'hA5C3;
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R8 busy pattern", v, 32'h0000_A5C3);

    // R9: reserved addresses
    wr(8'h04, 32'h0000_0070);
    foreach (e1[i]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [7:0] ra;
      ra = (k == 0) ? 8'h08 : (k == 1) ? 8'h0C : (k == 2) ? 8'h18 :
           (k == 3) ? 8'h20 : (k == 4) ? 8'h34 : 8'h02;
      wr(ra, 32'hFFFF_FFFF);
      rd(ra, v); check("R9 reserved read", v, 0);
    end
    rd(8'h04, v); check("R9 enable untouched", v, 32'h0000_0070);
    rd(8'h00, v); check("R9 enable0 untouched", v, 0);
    cyc(1'b0, 8'h00, '0, '0, '0, 16'h0200);          // ch9 queue
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R9 pending untouched", v, bit_of(9, 2));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule